// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns characters into asynchronous NRZ frames on a single serial line. A frame is a low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop bit. Timing comes from a one-cycle bit-rate tick supplied from outside. Each tick starts one bit slot.

A one-character holding register sits in front of an 11-bit shift register. Software can write the next character while the current one is still going out, and consecutive frames follow with no idle gap. Configuration inputs control several options. Parity can replace the top data bit. In 9-bit mode a ninth data bit is taken from its own input. Every level on the line, idle included, can be inverted. Two further actions are available: a break request and a preamble of ones that is sent whenever the transmitter is switched on. An empty flag shows when the holding register can take another character. A transmission-complete flag shows when the line has nothing left to send.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset the line sits at the idle level (1 when `invert` is 0), `empty` is 1 and `done` is 1. With nothing to send, every bit slot shows the idle level.
- R2: An 8-bit frame is 10 slots long: 0, then data bits 0 to 7, then 1. Each `bit_tick` starts one slot, and the line takes the new level in the cycle after the tick edge.
- R3: When `nine_bit` is 1 the frame is 11 slots long. Data bit 8 comes from `wr_bit8`, captured with the same write as `wr_data`.
- R4: When `par_en` is 1, the top data slot (bit 7 in 8-bit mode, bit 8 in 9-bit mode) carries a parity bit computed over the data bits below it. `par_odd`=1 gives odd total parity and `par_odd`=0 gives even.
- R5: The held character moves into the shift register on the first tick after the previous frame has ended. `empty` goes to 1 in the cycle after that tick, and a character written then is sent directly after the current frame with no idle slot between them.
- R6: A write while `empty` is 1 stores the character and clears `empty` in the next cycle. A write while `empty` is 0 is ignored and never reaches the line.
- R7: `done` is 1 only while `empty` is 1 and no data, preamble or break slot is pending or on the line.
- R8: A rising edge of `tx_en` sends a preamble of ones, 10 slots long in 8-bit mode and 11 in 9-bit mode, starting at the next tick and ahead of any held character.
- R9: Lowering `tx_en` lets the frame in progress finish. After that no new frame starts, and a held character stays held until the transmitter is enabled again.
- R10: While `brk_req` is 1 with the transmitter enabled, break characters of all zeros (frame length) are sent back to back. When the request is removed, the break that is under way completes and is followed by exactly one high slot.
- R11: When `invert` is 1, every level on `txd` is inverted: idle, preamble, start, data, stop and break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 8 | Character data bits 7..0 |
| wr_bit8 | input | 1 | Ninth data bit, written with `wr_data` |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Break request |
| nine_bit | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| par_en | input | 1 | Parity replaces the top data bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| invert | input | 1 | Invert every transmitted level |
| txd | output | 1 | Serial line |
| empty | output | 1 | Holding register can accept a character |
| done | output | 1 | Transmission complete |

## Verification
Line levels are registered on the tick edge. The monitor therefore samples `txd` 2 ns after each posedge at which `bit_tick` is high, and compares the sample with the next expected slot in a queue; when the queue is empty it expects the idle level. The driver writes characters and changes controls only on the negedge just after a tick, so every expected slot lines up with a known tick. `empty` is checked on the negedge one cycle after a write or a loading tick. `done` is checked on the negedge after the tick that ends the last slot, and again one tick earlier, where it must still be 0.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    // What the shift register is currently carrying
    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_PRE  = 3'd1,
        K_DATA = 3'd2,
        K_BRK  = 3'd3,
        K_TAIL = 3'd4
    } kind_e;

endpackage

// File: rtl/uart_tx_framer.sv
// Builds a complete frame (start, data, optional parity, stop) from a held word.
module uart_tx_framer #(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 3,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W:0]    word,
    input  logic               nine_bit,
    input  logic               par_en,
    input  logic               par_odd,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   len
);

    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(FRAME_W - 1);

    logic [DATA_W-1:0] body;
    logic              par_short;
    logic              par_long;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_body
            assign body[gi] = word[gi];
        end
    endgenerate

    assign par_short = (^word[DATA_W-2:0]) ^ par_odd;
    assign par_long  = (^word[DATA_W-1:0]) ^ par_odd;

    always_comb begin
        frame            = '1;
        frame[0]         = 1'b0;
        frame[DATA_W:1]  = body;
        if (!nine_bit) begin
            if (par_en) begin
                frame[DATA_W] = par_short;
            end
            len = LEN_SHORT;
        end else begin
            frame[DATA_W+1] = par_en ? par_long : word[DATA_W];
            len = LEN_LONG;
        end
    end

endmodule

// File: rtl/uart_tx_hold.sv
// One-character holding register with its empty flag.
module uart_tx_hold #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              take,
    output logic [WORD_W-1:0] word,
    output logic              empty
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              empty;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.empty = 1'b1;
        end
        if (wr_en && hold_q.empty) begin
            hold_d.word  = wr_word;
            hold_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '{word: '0, empty: 1'b1};
        end else begin
            hold_q <= hold_d;
        end
    end

    assign word  = hold_q.word;
    assign empty = hold_q.empty;

    // R6: an accepted write clears the flag
    p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_q.empty) |=> !hold_q.empty);

    // R6: a write while full leaves the held word alone
    p_full_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hold_q.empty && !take) |=> ($stable(hold_q.word) && !hold_q.empty));

    // R5: the sequencer only takes a character that is present
    p_take_needs_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !hold_q.empty);

    // R5: moving the character to the shifter frees the holding register
    p_take_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> hold_q.empty);

endmodule

// File: rtl/uart_tx_dbuf.sv
// Double-buffered serial transmitter: slot sequencer on top of holder and framer.
module uart_tx_dbuf
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit8,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              nine_bit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              invert,
    output logic              txd,
    output logic              empty,
    output logic              done
);

    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int WORD_W  = DATA_W + 1;

    typedef struct packed {
        logic               line;
        logic [FRAME_W-1:0] shift;
        logic [CNT_W-1:0]   cnt;
        logic               active;
        kind_e              kind;
        logic               pre_pend;
        logic               en_seen;
        logic               warm;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [WORD_W-1:0]  held_word;
    logic               hold_empty;
    logic               take;
    logic [FRAME_W-1:0] data_frame;
    logic [CNT_W-1:0]   frame_len;

    uart_tx_hold #(.WORD_W(WORD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word ({wr_bit8, wr_data}),
        .take    (take),
        .word    (held_word),
        .empty   (hold_empty)
    );

    uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
        .word     (held_word),
        .nine_bit (nine_bit),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .frame    (data_frame),
        .len      (frame_len)
    );

    always_comb begin
        seq_d         = seq_q;
        take          = 1'b0;
        seq_d.warm    = 1'b1;
        seq_d.en_seen = tx_en;
        if (tx_en && !seq_q.en_seen) begin
            seq_d.pre_pend = 1'b1;
        end
        if (!tx_en) begin
            seq_d.pre_pend = 1'b0;
        end

        if (bit_tick) begin
            if (seq_q.cnt != '0) begin
                // next slot of the frame under way
                seq_d.line  = seq_q.shift[0];
                seq_d.shift = {1'b1, seq_q.shift[FRAME_W-1:1]};
                seq_d.cnt   = seq_q.cnt - 1'b1;
            end else if (seq_q.pre_pend && tx_en) begin
                seq_d.line     = 1'b1;
                seq_d.shift    = '1;
                seq_d.cnt      = frame_len - 1'b1;
                seq_d.active   = 1'b1;
                seq_d.kind     = K_PRE;
                seq_d.pre_pend = 1'b0;
            end else if (brk_req && tx_en) begin
                seq_d.line   = 1'b0;
                seq_d.shift  = '0;
                seq_d.cnt    = frame_len - 1'b1;
                seq_d.active = 1'b1;
                seq_d.kind   = K_BRK;
            end else if (seq_q.active && (seq_q.kind == K_BRK)) begin
                // single high slot closing a break
                seq_d.line   = 1'b1;
                seq_d.shift  = '1;
                seq_d.cnt    = '0;
                seq_d.active = 1'b1;
                seq_d.kind   = K_TAIL;
            end else if (!hold_empty && tx_en) begin
                take         = 1'b1;
                seq_d.line   = data_frame[0];
                seq_d.shift  = {1'b1, data_frame[FRAME_W-1:1]};
                seq_d.cnt    = frame_len - 1'b1;
                seq_d.active = 1'b1;
                seq_d.kind   = K_DATA;
            end else begin
                seq_d.line   = 1'b1;
                seq_d.shift  = '1;
                seq_d.active = 1'b0;
                seq_d.kind   = K_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{line: 1'b1, shift: '1, cnt: '0, active: 1'b0, kind: K_NONE,
                       pre_pend: 1'b0, en_seen: 1'b0, warm: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign txd   = seq_q.line ^ invert;
    assign empty = hold_empty;
    assign done  = hold_empty && !seq_q.active && !seq_q.pre_pend;

    // R7: completion implies the holding register is free
    p_done_needs_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> empty);

    // R2: the line only moves after a tick
    p_line_held_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.warm && !$past(bit_tick)) |-> $stable(seq_q.line));

    // R10: break slots drive the active (low) level
    p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && seq_q.kind == K_BRK) |-> (txd == invert));

    // R10: the closing slot after a break is high
    p_break_tail_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && seq_q.kind == K_TAIL) |-> (txd == !invert));

    // R8: preamble slots are all ones
    p_preamble_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && seq_q.kind == K_PRE) |-> (txd == !invert));

    // R11: the idle line shows the inverted-aware idle level
    p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.active |-> (txd == !invert));

endmodule

// File: tb/uart_tx_dbuf_tb.sv
module uart_tx_dbuf_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_bit8 = 1'b0;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic       nine_bit = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       invert = 1'b0;
    logic       txd;
    logic       empty;
    logic       done;

    int   n_checks = 0;
    int   n_errors = 0;
    logic mon_on = 1'b0;
    logic finished = 1'b0;
    logic [1:0] tdiv = 2'd0;

    logic  exp_bits[$];
    string exp_tags[$];

    uart_tx_dbuf u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_bit8  (wr_bit8),
        .tx_en    (tx_en),
        .brk_req  (brk_req),
        .nine_bit (nine_bit),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .invert   (invert),
        .txd      (txd),
        .empty    (empty),
        .done     (done)
    );

    always #4 clk = ~clk;

    // bit-rate tick: one pulse every four cycles, driven away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            tdiv     <= 2'd0;
            bit_tick <= 1'b0;
        end else begin
            tdiv     <= tdiv + 2'd1;
            bit_tick <= (tdiv == 2'd3);
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic push_bit(input logic b, input string tag);
        exp_bits.push_back(b ^ invert);
        exp_tags.push_back(tag);
    endtask

    task automatic push_ones(input int n, input string tag);
        for (int i = 0; i < n; i++) push_bit(1'b1, tag);
    endtask

    // expected frame built from R2, R3, R4
    task automatic push_frame(input logic [7:0] d, input logic b8, input string tag);
        int nd;
        logic [8:0] w;
        logic p;
        nd = nine_bit ? 9 : 8;
        w  = {b8, d};
        if (par_en) begin
            p = par_odd;
            for (int i = 0; i < nd - 1; i++) p = p ^ w[i];
            w[nd-1] = p;
        end
        push_bit(1'b0, "R2");
        for (int i = 0; i < nd; i++) push_bit(w[i], tag);
        push_bit(1'b1, "R2");
    endtask

    // returns on the negedge just after the next tick edge
    task automatic after_tick();
        do @(posedge clk); while (!bit_tick);
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) after_tick();
    endtask

    task automatic write_char(input logic [7:0] d, input logic b8);
        wr_data = d;
        wr_bit8 = b8;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // monitor: pops one expected slot per tick, else expects idle
    always begin
        @(posedge clk);
        if (mon_on && bit_tick) begin
            #2;
            if (exp_bits.size() > 0) begin
                chk(exp_tags.pop_front(), txd, exp_bits.pop_front(), "line slot");
            end else begin
                chk("R1", txd, ~invert, "idle slot");
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", txd, 1'b1, "reset line");
        chk("R1", empty, 1'b1, "reset empty");
        chk("R1", done, 1'b1, "reset done");
        mon_on = 1'b1;

        // R8 preamble on enable, then R6 write and ignored write
        after_tick();
        tx_en = 1'b1;
        push_ones(10, "R8");
        @(negedge clk);
        chk("R7", done, 1'b0, "done low with preamble pending");
        write_char(8'hA5, 1'b0);
        push_frame(8'hA5, 1'b0, "R2");
        chk("R6", empty, 1'b0, "empty after write");
        write_char(8'h3C, 1'b0);           // ignored, R6
        chk("R6", empty, 1'b0, "empty after ignored write");
        wait_ticks(10);
        chk("R5", empty, 1'b0, "held during preamble");
        wait_ticks(1);
        chk("R5", empty, 1'b1, "empty after load");
        chk("R7", done, 1'b0, "done low while sending");
        write_char(8'h5A, 1'b0);           // back-to-back, R5
        push_frame(8'h5A, 1'b0, "R5");
        wait_ticks(19);
        chk("R7", done, 1'b0, "done low in last stop slot");
        wait_ticks(1);
        chk("R7", done, 1'b1, "done after last slot");

        // R3 nine-bit frames
        nine_bit = 1'b1;
        write_char(8'h96, 1'b1);
        push_frame(8'h96, 1'b1, "R3");
        wait_ticks(12);
        write_char(8'h0F, 1'b0);
        push_frame(8'h0F, 1'b0, "R3");
        wait_ticks(12);

        // R4 parity, both senses, both lengths
        nine_bit = 1'b0; par_en = 1'b1; par_odd = 1'b0;
        write_char(8'h07, 1'b0);
        push_frame(8'h07, 1'b0, "R4");
        wait_ticks(11);
        par_odd = 1'b1;
        write_char(8'h07, 1'b0);
        push_frame(8'h07, 1'b0, "R4");
        wait_ticks(11);
        nine_bit = 1'b1; par_odd = 1'b0;
        write_char(8'hE1, 1'b0);
        push_frame(8'hE1, 1'b0, "R4");
        wait_ticks(12);
        par_odd = 1'b1;
        write_char(8'hE1, 1'b1);
        push_frame(8'hE1, 1'b1, "R4");
        wait_ticks(12);
        nine_bit = 1'b0; par_en = 1'b0; par_odd = 1'b0;

        // R10 continuous break, then the closing high slot
        brk_req = 1'b1;
        for (int i = 0; i < 20; i++) push_bit(1'b0, "R10");
        wait_ticks(1);
        chk("R10", done, 1'b0, "done low in break");
        wait_ticks(11);
        brk_req = 1'b0;
        push_bit(1'b1, "R10");
        wait_ticks(9);
        chk("R10", done, 1'b0, "done low in closing slot");
        wait_ticks(1);
        chk("R10", done, 1'b1, "done after break");

        // R9 disable mid-frame
        write_char(8'hC3, 1'b0);
        push_frame(8'hC3, 1'b0, "R9");
        wait_ticks(4);
        tx_en = 1'b0;
        write_char(8'h81, 1'b0);
        chk("R9", empty, 1'b0, "second char held");
        wait_ticks(16);
        chk("R9", empty, 1'b0, "held while disabled");
        chk("R9", done, 1'b0, "not done while char held");
        tx_en = 1'b1;
        push_ones(10, "R8");
        push_frame(8'h81, 1'b0, "R9");
        wait_ticks(22);
        chk("R9", done, 1'b1, "done after re-enable");

        // R11 inversion of idle and frame
        invert = 1'b1;
        @(negedge clk);
        chk("R11", txd, 1'b0, "inverted idle");
        after_tick();
        write_char(8'h55, 1'b0);
        push_frame(8'h55, 1'b0, "R11");
        wait_ticks(12);
        invert = 1'b0;
        @(negedge clk);
        chk("R11", txd, 1'b1, "idle after inversion off");

        wait_ticks(3);
        chk("R2", exp_bits.size() == 0, 1'b1, "all expected slots seen");
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule